// File: doc/BRIEF.md
# Three-Colour Linear Sensor Line Timing Generator

This block turns one fast system clock into the digital drive waveforms for a three-colour linear charge-coupled image sensor. Each line opens with a transfer phase: the three colour transfer gates pulse together while the shift clocks are parked, with a programmable quiet gap on each side of the pulse. The block then clocks every pixel position out through a pair of complementary shift clocks. A reset-gate pulse and a clamp pulse run all the time, through the transfer phase and between lines as well. A sample strobe marks the video level of each pixel that is clocked out.

Along with the drive signals, the block gives the position of each strobed pixel within the line and a class tag. A later stage uses the tag to separate lead-in dummy cells, shielded reference cells, unusable cells and image cells. Software sets the pixel period, the transfer pulse width and the guard gap through a small write port. A value it writes is taken into use only when the next line begins. A start request that arrives while a line is running is held and launches the next line as soon as the current one ends.

Top module: `ccdLineTimer`

## Requirements
- R1: After reset, phi1 is 1, phi2 is 0, every transfer gate is 0, lineValid, lineDone and sampleStrobe are 0, and pixIndex is 0.
- R2: During the pixel stage, phi1 is low for floor(P/2) system cycles at the start of each pixel period of P cycles and high for the rest of it. phi2 is always the inverse of phi1, so the two are never low together. Outside the pixel stage, phi1 is 1 and phi2 is 0.
- R3: The pixel phase runs freely at all times. rstGate is high for one cycle at phase 0 and clampPulse for one cycle at phase 1, in idle, in the transfer phase and in the pixel stage alike. sampleStrobe is high for one cycle at phase P-1, and only in the pixel stage.
- R4: All transfer-gate outputs rise and fall in the same cycles. Each line has exactly one gate pulse, and it is high for exactly W cycles.
- R5: The gate pulse rises exactly G cycles after lineValid rises at the start of a line. The first phi1 fall of the line comes at least G and at most G+P-1 cycles after the gate falls, because the pixel stage waits for the phase to wrap. phi1 and phi2 do not change while the gate is high.
- R6: A line strobes exactly NPIX = N_DUMMY+N_OB+N_LEAD_INV+N_VALID+N_TRAIL_INV samples. pixIndex reads 0, 1, … NPIX-1 in that order at those strobes.
- R7: pixClass at each strobe encodes the position: 0 for the first N_DUMMY positions, 1 for the next N_OB, 2 for the next N_LEAD_INV, 3 for the next N_VALID, and 2 for the last N_TRAIL_INV.
- R8: lineDone is high for one cycle, in the same cycle as the last sample strobe of the line. If no start is pending, lineValid is 0 from the cycle after that.
- R9: A start that arrives while a line runs is held. The next line's lineValid period begins in the cycle right after lineDone. Several starts during one line produce only one further line.
- R10: A configuration write goes into a shadow copy. It is taken into use only when the next line starts. Address 0 holds the pixel period P, address 1 the gate width W and address 2 the guard gap G, all in system cycles.
- R11: A pixel period written below 4 is stored as 4. A gate width or guard gap written as 0 is stored as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Line start request, one-cycle pulse |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 2 | Configuration address (0 period, 1 gate width, 2 guard) |
| cfgData | input | CFG_W | Configuration write data |
| phi1 | output | 1 | Shift clock, first phase |
| phi2 | output | 1 | Shift clock, second phase |
| rstGate | output | 1 | Reset-gate pulse, once per pixel period |
| clampPulse | output | 1 | Reset-level clamp pulse, once per pixel period |
| sampleStrobe | output | 1 | Video-level sample strobe in the pixel stage |
| tgPulse | output | NUM_COLORS | Transfer-gate pulses, one per colour |
| pixIndex | output | IDX_W | Position of the current pixel within the line |
| pixClass | output | 2 | Class tag of the current pixel |
| lineValid | output | 1 | High while a line is in progress |
| lineDone | output | 1 | One-cycle end-of-line pulse |

## Verification
The hardest case to reach is the handover between lines. A start is held while a line runs, and the following transfer phase then runs straight after the last pixel with no idle cycle. In the same window, a configuration written in the middle of the line must stay out of use until the new line begins. The bench issues two start pulses and a shadow write in parallel with capturing a running line. It then measures the second line's start cycle against the first line's lineDone, and checks the old and new pixel periods line by line. The guard window after the gate pulse depends on where the free-running phase happens to be, so the bench also uses an odd period and the minimum values to vary that alignment.

// File: rtl/ccdTimPkg.sv
`timescale 1ns/1ps
package ccdTimPkg;

  typedef enum logic [1:0] {
    PC_DUMMY   = 2'd0,
    PC_OBLACK  = 2'd1,
    PC_INVALID = 2'd2,
    PC_VALID   = 2'd3
  } pixClass_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_PIX
  } lineSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic inPix;
    logic tgOn;
    logic lineActive;
    logic lineEnd;
    logic pixStep;
  } ctrlStrb_t;

  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_TGW    = 2'd1;
  localparam logic [1:0] ADDR_GUARD  = 2'd2;

endpackage

// File: rtl/ccdTimCtrl.sv
`timescale 1ns/1ps
module ccdTimCtrl
  import ccdTimPkg::*;
#(
  parameter int CFG_W          = 16,
  parameter int MIN_PIX_PERIOD = 4,
  parameter int DEF_PIX_PERIOD = 50,
  parameter int DEF_TG_WIDTH   = 1250,
  parameter int DEF_GUARD      = 225
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             phEnd,
  input  logic             lastPix,
  output ctrlStrb_t        strb,
  output logic [CFG_W-1:0] actPer,
  output logic [CFG_W-1:0] actTgW,
  output logic [CFG_W-1:0] actGuard
);

  localparam logic [CFG_W-1:0] MIN_PER = CFG_W'(MIN_PIX_PERIOD);
  localparam logic [CFG_W-1:0] ONE     = CFG_W'(1);

  function automatic logic [CFG_W-1:0] atLeast(input logic [CFG_W-1:0] v,
                                               input logic [CFG_W-1:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  logic [CFG_W-1:0] shPer, shTgW, shGuard;
  lineSt_e          st, stNext;
  logic [CFG_W-1:0] segCnt, segLim;
  logic             segDone, lineEnd, goLine, pend;

  // shadow configuration, written at any time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shPer   <= atLeast(CFG_W'(DEF_PIX_PERIOD), MIN_PER);
      shTgW   <= atLeast(CFG_W'(DEF_TG_WIDTH), ONE);
      shGuard <= atLeast(CFG_W'(DEF_GUARD), ONE);
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_PERIOD: shPer   <= atLeast(cfgData, MIN_PER);
        ADDR_TGW:    shTgW   <= atLeast(cfgData, ONE);
        ADDR_GUARD:  shGuard <= atLeast(cfgData, ONE);
        default: ;
      endcase
    end
  end

  assign segLim  = (st == ST_XFER) ? actTgW : actGuard;
  assign segDone = (segCnt >= segLim - ONE);
  assign lineEnd = (st == ST_PIX) && phEnd && lastPix;
  assign goLine  = ((st == ST_IDLE) && start) || (lineEnd && (pend || start));

  always_comb begin
    stNext = st;
    case (st)
      ST_IDLE:  if (start) stNext = ST_SETUP;
      ST_SETUP: if (segDone) stNext = ST_XFER;
      ST_XFER:  if (segDone) stNext = ST_HOLD;
      ST_HOLD:  if (segDone && phEnd) stNext = ST_PIX;
      ST_PIX:   if (lineEnd) stNext = (pend || start) ? ST_SETUP : ST_IDLE;
      default:  stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      segCnt <= '0;
      pend   <= 1'b0;
    end else begin
      st <= stNext;
      if (stNext != st)  segCnt <= '0;
      else if (!segDone) segCnt <= segCnt + ONE;
      if (goLine)                         pend <= 1'b0;
      else if (start && st != ST_IDLE)    pend <= 1'b1;
    end
  end

  // active configuration, loaded at a line boundary only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actPer   <= atLeast(CFG_W'(DEF_PIX_PERIOD), MIN_PER);
      actTgW   <= atLeast(CFG_W'(DEF_TG_WIDTH), ONE);
      actGuard <= atLeast(CFG_W'(DEF_GUARD), ONE);
    end else if (goLine) begin
      actPer   <= shPer;
      actTgW   <= shTgW;
      actGuard <= shGuard;
    end
  end

  always_comb begin
    strb.inPix      = (st == ST_PIX);
    strb.tgOn       = (st == ST_XFER);
    strb.lineActive = (st != ST_IDLE);
    strb.lineEnd    = lineEnd;
    strb.pixStep    = (st == ST_PIX) && phEnd;
  end

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE && !lineEnd) |=> ($stable(actPer) && $stable(actTgW) && $stable(actGuard)));

  p_cfg_floor_r11: assert property (@(posedge clk) disable iff (!rstN)
    (actPer >= MIN_PER) && (actTgW != '0) && (actGuard != '0));

  p_pend_launch_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lineEnd && pend) |=> (st == ST_SETUP));

  p_idle_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && start) |=> (st == ST_SETUP));

endmodule

// File: rtl/ccdTimDatapath.sv
`timescale 1ns/1ps
module ccdTimDatapath
  import ccdTimPkg::*;
#(
  parameter int CFG_W       = 16,
  parameter int NUM_COLORS  = 3,
  parameter int N_DUMMY     = 15,
  parameter int N_OB        = 49,
  parameter int N_LEAD_INV  = 3,
  parameter int N_VALID     = 10600,
  parameter int N_TRAIL_INV = 2,
  parameter int IDX_W       = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrb_t             strb,
  input  logic [CFG_W-1:0]      actPer,
  input  logic [CFG_W-1:0]      actTgW,
  input  logic [CFG_W-1:0]      actGuard,
  output logic                  phEnd,
  output logic                  lastPix,
  output logic                  phi1,
  output logic                  phi2,
  output logic                  rstGate,
  output logic                  clampPulse,
  output logic                  sampleStrobe,
  output logic [NUM_COLORS-1:0] tgPulse,
  output logic [IDX_W-1:0]      pixIndex,
  output logic [1:0]            pixClass,
  output logic                  lineValid,
  output logic                  lineDone
);

  localparam int NPIX   = N_DUMMY + N_OB + N_LEAD_INV + N_VALID + N_TRAIL_INV;
  localparam int B_OB   = N_DUMMY;
  localparam int B_LINV = B_OB + N_OB;
  localparam int B_VAL  = B_LINV + N_LEAD_INV;
  localparam int B_TINV = B_VAL + N_VALID;
  localparam logic [CFG_W-1:0] ONE = CFG_W'(1);

  function automatic pixClass_e classOf(input logic [IDX_W-1:0] p);
    int i;
    i = int'(p);
    if (i < B_OB)   return PC_DUMMY;
    if (i < B_LINV) return PC_OBLACK;
    if (i < B_VAL)  return PC_INVALID;
    if (i < B_TINV) return PC_VALID;
    return PC_INVALID;
  endfunction

  logic [CFG_W-1:0] ph, half;
  logic [IDX_W-1:0] idx;
  logic             phWrap;

  assign half    = actPer >> 1;
  assign phEnd   = (ph == actPer - ONE);
  assign phWrap  = (ph >= actPer - ONE);
  assign lastPix = (idx == IDX_W'(NPIX - 1));

  // free-running pixel phase
  always_ff @(posedge clk) begin
    if (!rstN)       ph <= '0;
    else if (phWrap) ph <= '0;
    else             ph <= ph + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             idx <= '0;
    else if (strb.pixStep) idx <= lastPix ? '0 : idx + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phi1         <= 1'b1;
      phi2         <= 1'b0;
      rstGate      <= 1'b0;
      clampPulse   <= 1'b0;
      sampleStrobe <= 1'b0;
      pixIndex     <= '0;
      pixClass     <= PC_DUMMY;
      lineValid    <= 1'b0;
      lineDone     <= 1'b0;
    end else begin
      phi1         <= strb.inPix ? (ph >= half) : 1'b1;
      phi2         <= strb.inPix ? (ph < half)  : 1'b0;
      rstGate      <= (ph == '0);
      clampPulse   <= (ph == ONE);
      sampleStrobe <= strb.inPix && phEnd;
      pixIndex     <= idx;
      pixClass     <= classOf(idx);
      lineValid    <= strb.lineActive;
      lineDone     <= strb.lineEnd;
    end
  end

  for (genvar c = 0; c < NUM_COLORS; c++) begin : g_tg
    always_ff @(posedge clk) begin
      if (!rstN) tgPulse[c] <= 1'b0;
      else       tgPulse[c] <= strb.tgOn;
    end
  end

  // checker state
  logic [CFG_W-1:0] tgRun, gapCnt;
  logic             awaitFirst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgRun      <= '0;
      gapCnt     <= '0;
      awaitFirst <= 1'b0;
    end else begin
      tgRun <= tgPulse[0] ? tgRun + ONE : '0;
      if (tgPulse[0])          gapCnt <= '0;
      else if (gapCnt != '1)   gapCnt <= gapCnt + ONE;
      if (tgPulse[0])          awaitFirst <= 1'b1;
      else if (!phi1)          awaitFirst <= 1'b0;
    end
  end

  p_shift_cross_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phi1 || phi2) && (phi1 != phi2));

  p_rst_then_clamp_r3: assert property (@(posedge clk) disable iff (!rstN)
    rstGate |=> clampPulse);

  p_sample_alone_r3: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> (!rstGate && !clampPulse && lineValid));

  p_tg_together_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(tgPulse) == 0) || ($countones(tgPulse) == NUM_COLORS));

  p_tg_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgPulse[0]) |-> (tgRun == actTgW));

  p_tg_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    tgPulse[0] |-> (phi1 && !phi2 && !sampleStrobe));

  p_hold_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(phi1) && awaitFirst) |->
      ((gapCnt >= actGuard) && (int'(gapCnt) < int'(actGuard) + int'(actPer))));

  p_done_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> (sampleStrobe && pixIndex == IDX_W'(NPIX - 1)));

endmodule

// File: rtl/ccdLineTimer.sv
`timescale 1ns/1ps
module ccdLineTimer
  import ccdTimPkg::*;
#(
  parameter int CFG_W          = 16,
  parameter int NUM_COLORS     = 3,
  parameter int N_DUMMY        = 15,
  parameter int N_OB           = 49,
  parameter int N_LEAD_INV     = 3,
  parameter int N_VALID        = 10600,
  parameter int N_TRAIL_INV    = 2,
  parameter int MIN_PIX_PERIOD = 4,
  parameter int DEF_PIX_PERIOD = 50,
  parameter int DEF_TG_WIDTH   = 1250,
  parameter int DEF_GUARD      = 225,
  parameter int IDX_W = $clog2(N_DUMMY + N_OB + N_LEAD_INV + N_VALID + N_TRAIL_INV)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgAddr,
  input  logic [CFG_W-1:0]      cfgData,
  output logic                  phi1,
  output logic                  phi2,
  output logic                  rstGate,
  output logic                  clampPulse,
  output logic                  sampleStrobe,
  output logic [NUM_COLORS-1:0] tgPulse,
  output logic [IDX_W-1:0]      pixIndex,
  output logic [1:0]            pixClass,
  output logic                  lineValid,
  output logic                  lineDone
);

  ctrlStrb_t        strb;
  logic [CFG_W-1:0] actPer, actTgW, actGuard;
  logic             phEnd, lastPix;

  ccdTimCtrl #(
    .CFG_W(CFG_W), .MIN_PIX_PERIOD(MIN_PIX_PERIOD), .DEF_PIX_PERIOD(DEF_PIX_PERIOD),
    .DEF_TG_WIDTH(DEF_TG_WIDTH), .DEF_GUARD(DEF_GUARD)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .phEnd(phEnd), .lastPix(lastPix), .strb(strb),
    .actPer(actPer), .actTgW(actTgW), .actGuard(actGuard)
  );

  ccdTimDatapath #(
    .CFG_W(CFG_W), .NUM_COLORS(NUM_COLORS), .N_DUMMY(N_DUMMY), .N_OB(N_OB),
    .N_LEAD_INV(N_LEAD_INV), .N_VALID(N_VALID), .N_TRAIL_INV(N_TRAIL_INV), .IDX_W(IDX_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .actPer(actPer), .actTgW(actTgW),
    .actGuard(actGuard), .phEnd(phEnd), .lastPix(lastPix), .phi1(phi1), .phi2(phi2),
    .rstGate(rstGate), .clampPulse(clampPulse), .sampleStrobe(sampleStrobe),
    .tgPulse(tgPulse), .pixIndex(pixIndex), .pixClass(pixClass),
    .lineValid(lineValid), .lineDone(lineDone)
  );

endmodule

// File: tb/test_ccdLineTimer.sv
`timescale 1ns/1ps
module test_ccdLineTimer;

  localparam int D = 2, OB = 3, LI = 1, V = 6, TI = 2;
  localparam int NPIX = D + OB + LI + V + TI;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [15:0] cfgData = 16'd0;
  logic       phi1, phi2, rstGate, clampPulse, sampleStrobe, lineValid, lineDone;
  logic [2:0] tg;
  logic [3:0] pixIndex;
  logic [1:0] pixClass;

  ccdLineTimer #(
    .N_DUMMY(D), .N_OB(OB), .N_LEAD_INV(LI), .N_VALID(V), .N_TRAIL_INV(TI),
    .DEF_PIX_PERIOD(6), .DEF_TG_WIDTH(20), .DEF_GUARD(5)
  ) i_ccdLineTimer (
    .clk(clk), .rstN(rstN), .start(start), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .phi1(phi1), .phi2(phi2), .rstGate(rstGate),
    .clampPulse(clampPulse), .sampleStrobe(sampleStrobe), .tgPulse(tg),
    .pixIndex(pixIndex), .pixClass(pixClass), .lineValid(lineValid), .lineDone(lineDone)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  int mStart, mTgRise, mTgFall, mPhiFall, mTgPulses, mTgSplit, mLowLen, mLowVar;
  int mOverlap, mOrderErr, mRstInTg, mSamples, mIdxErr, mClsErr, mDoneOk, mDone;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expClass(input int p);
    if (p < D) return 0;
    if (p < D + OB) return 1;
    if (p < D + OB + LI) return 2;
    if (p < D + OB + LI + V) return 3;
    return 2;
  endfunction

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic writeCfg(input logic [1:0] a, input int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = 16'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // records one line, from the lineValid period start up to lineDone
  task automatic captureLine();
    int lowRun;
    logic pPhi, pTg, pRst;
    mTgRise = -1; mTgFall = -1; mPhiFall = -1; mTgPulses = 0; mTgSplit = 0;
    mLowLen = -1; mLowVar = 0; mOverlap = 0; mOrderErr = 0; mRstInTg = 0;
    mSamples = 0; mIdxErr = 0; mClsErr = 0; mDoneOk = 0; mDone = -1;
    do @(negedge clk); while (!lineValid);
    mStart = cyc; pPhi = 1'b1; pTg = 1'b0; pRst = 1'b0; lowRun = 0;
    while (1) begin
      if (tg != 3'b000 && tg != 3'b111) mTgSplit++;
      if (tg[0] && !pTg) begin mTgRise = cyc; mTgPulses++; end
      if (!tg[0] && pTg) mTgFall = cyc;
      if (rstGate && tg[0]) mRstInTg++;
      if (phi1 == phi2) mOverlap++;
      if (pRst && !clampPulse) mOrderErr++;
      if (sampleStrobe && (rstGate || clampPulse)) mOrderErr++;
      if (!phi1 && pPhi && mPhiFall < 0) mPhiFall = cyc;
      if (!phi1) lowRun++;
      else if (!pPhi) begin
        if (mLowLen < 0) mLowLen = lowRun;
        else if (lowRun != mLowLen) mLowVar++;
        lowRun = 0;
      end
      if (sampleStrobe) begin
        if (int'(pixIndex) != mSamples) mIdxErr++;
        if (int'(pixClass) != expClass(mSamples)) mClsErr++;
        mSamples++;
      end
      if (lineDone) begin
        mDone = cyc;
        mDoneOk = (sampleStrobe && mSamples == NPIX) ? 1 : 0;
        break;
      end
      pPhi = phi1; pTg = tg[0]; pRst = rstGate;
      @(negedge clk);
    end
  endtask

  task automatic verifyLine(input string tag, input int P, input int W, input int G);
    int gap;
    gap = mPhiFall - mTgFall;
    chk(mTgRise - mStart == G, "R5", {tag, " gate rise after line start"}, mTgRise - mStart, G);
    chk(mTgFall - mTgRise == W, "R4", {tag, " gate width"}, mTgFall - mTgRise, W);
    chk(mTgPulses == 1 && mTgSplit == 0, "R4", {tag, " gate pulses (+10*split)"},
        mTgPulses + 10 * mTgSplit, 1);
    chk(gap >= G && gap <= G + P - 1, "R5", {tag, " gate fall to first phi1 fall"}, gap, G);
    chk(mLowLen == P / 2 && mLowVar == 0 && mOverlap == 0, "R2",
        {tag, " phi1 low length (+100*bad)"}, mLowLen + 100 * (mLowVar + mOverlap), P / 2);
    chk(mOrderErr == 0 && mRstInTg >= W / P, "R3", {tag, " pulse order / reset during gate"},
        mRstInTg - 100 * mOrderErr, W / P);
    chk(mSamples == NPIX && mIdxErr == 0, "R6", {tag, " sample count (+100*index err)"},
        mSamples + 100 * mIdxErr, NPIX);
    chk(mClsErr == 0, "R7", {tag, " class tag errors"}, mClsErr, 0);
    chk(mDoneOk == 1, "R8", {tag, " lineDone with last sample"}, mDoneOk, 1);
  endtask

  task automatic testReset();
    int nRst, nClamp, nSamp;
    nRst = 0; nClamp = 0; nSamp = 0;
    @(negedge clk);
    chk(phi1 && !phi2 && tg == 3'b000 && !lineValid && !lineDone && !sampleStrobe
        && pixIndex == 4'd0, "R1", "reset state",
        {phi1, phi2, tg, lineValid, lineDone, sampleStrobe}, 8'b1000_0000);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      nRst += int'(rstGate); nClamp += int'(clampPulse); nSamp += int'(sampleStrobe);
    end
    chk(nRst == 4 && nClamp == 4, "R3", "idle reset/clamp pulses in 24 cycles", nRst + nClamp, 8);
    chk(nSamp == 0 && phi1 && !phi2, "R2", "idle: no strobe, shift clocks parked", nSamp, 0);
  endtask

  task automatic testBasic();
    writeCfg(2'd0, 6); writeCfg(2'd1, 20); writeCfg(2'd2, 5);
    pulseStart();
    captureLine();
    verifyLine("basic", 6, 20, 5);
    @(negedge clk);
    chk(!lineValid, "R8", "lineValid low after done", int'(lineValid), 0);
  endtask

  task automatic testOdd();
    writeCfg(2'd0, 7); writeCfg(2'd1, 9); writeCfg(2'd2, 3);
    pulseStart();
    captureLine();
    verifyLine("odd", 7, 9, 3);
  endtask

  task automatic testBackToBack();
    int doneA, highs;
    writeCfg(2'd0, 6); writeCfg(2'd1, 20); writeCfg(2'd2, 5);
    pulseStart();
    fork
      begin
        captureLine();
        verifyLine("b2b-A", 6, 20, 5);
        doneA = mDone;
        captureLine();
        verifyLine("b2b-B", 6, 20, 5);
        chk(mStart == doneA + 1, "R9", "held start launches next line at once",
            mStart - doneA, 1);
      end
      begin
        repeat (40) @(negedge clk);
        pulseStart();
        repeat (10) @(negedge clk);
        pulseStart();
      end
    join
    highs = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      highs += int'(lineValid);
    end
    chk(highs == 0, "R9", "two held starts give one extra line", highs, 0);
  endtask

  task automatic testMidWrite();
    writeCfg(2'd0, 6); writeCfg(2'd1, 20); writeCfg(2'd2, 5);
    pulseStart();
    fork
      captureLine();
      begin
        repeat (30) @(negedge clk);
        writeCfg(2'd0, 8);
        writeCfg(2'd1, 12);
      end
    join
    verifyLine("R10 old", 6, 20, 5);
    pulseStart();
    captureLine();
    verifyLine("R10 new", 8, 12, 5);
  endtask

  task automatic testMinClamp();
    writeCfg(2'd0, 2); writeCfg(2'd1, 0); writeCfg(2'd2, 0);
    pulseStart();
    captureLine();
    verifyLine("R11 floor", 4, 1, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testOdd();
    testBackToBack();
    testMidWrite();
    testMinClamp();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R8 watchdog expired: actual %0d expected %0d (cycles)", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule